// File: doc/BRIEF.md
# Flash Program and Page-Erase Sequencer

This block sits between a simple register bus and an on-chip flash array. Software loads a target address and up to four 32-bit data words, then writes the control register to start a program or a page erase. The controller checks the command, and a command that passes starts an operation on the array port. A command that fails sets an access-fail flag. The array port carries single-cycle program and erase strobes. The address, data and word enables sit beside the strobes.

A command is judged against the unlock key and the erase code carried in the same control write. While an operation runs, the busy bit reads 1 and the controller holds it for a fixed latency. On completion the busy bit and the command bit clear themselves, the unlock field locks again and the done flag is set. The flags are write-1-to-clear. Each flag drives the interrupt only when its enable bit is set.

Register map (word index `bus_addr[4:2]`): 0 target address, 1 to 4 data words 0 to 3, 5 control, 6 interrupt.

Control fields:
- `[0]` program
- `[1]` page erase
- `[4]` wide (1 = 128-bit)
- `[11:8]` unlock key
- `[23:16]` erase code
- `[31]` busy (read-only)

Interrupt fields:
- `[0]` done
- `[1]` access fail
- `[8]` done enable
- `[9]` fail enable

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every register reads zero, busy is 0, no strobe is active and `irq` is 0.
- R2: A program or erase request whose unlock field (control `[11:8]`) is not 0x2 does not strobe the array and sets access fail (interrupt `[1]`).
- R3: A 32-bit program (control `[4]`=0) needs a 4-byte aligned address. It strobes `arr_prog` once, with `arr_wmask` one-hot at lane `addr[3:2]` and data word 0 placed in that lane of `arr_wdata`.
- R4: A 128-bit program (control `[4]`=1) needs a 16-byte aligned address. It drives `arr_wmask`=4'hF and `arr_wdata`={word3,word2,word1,word0}. A misaligned address for either width sets access fail and gives no strobe.
- R5: After an accepted program, busy reads 1 for exactly PROG_LAT (default 4) cycles. After that the program bit (control `[0]`) reads 0 again.
- R6: A page erase with an erase code (control `[23:16]`) other than 0x55 fails with access fail and gives no strobe.
- R7: An accepted erase strobes `arr_erase` once with `arr_addr` equal to the target address with bits [12:0] cleared. Busy reads 1 for ERASE_LAT (default 16) cycles and then clears together with the erase bit (control `[1]`).
- R8: A target address with any of bits [31:18] set fails both commands with access fail.
- R9: On completion the done flag (interrupt `[0]`) is set and the unlock field reads 0. A failed command also returns the unlock field to 0.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it. The enable bits are read/write.
- R11: `irq` is high when (done and done enable) or (access fail and fail enable).
- R12: A control write while busy is 1 has no effect.
- R13: A control write that sets both the program and erase bits fails with access fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte offset of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| arr_prog | output | 1 | One-cycle program strobe |
| arr_erase | output | 1 | One-cycle page-erase strobe |
| arr_addr | output | 32 | Array address for the strobe |
| arr_wdata | output | 128 | Program data |
| arr_wmask | output | 4 | Word enables for program |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a control write that arrives while an operation is still running. It must be dropped whole, and it must neither fail nor start anything. The bench starts a 16-cycle erase and writes a fully valid program command a few cycles in. It then waits for completion and checks three things: no program strobe, no access fail, and the erase code still in the register. The fail paths are each driven alone with every other condition valid, so that each check covers exactly one rejection reason.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int unsigned PAGE_LSB   = 13,
  parameter int unsigned PAGE_SEL_W = 5,
  parameter int unsigned PROG_LAT   = 4,
  parameter int unsigned ERASE_LAT  = 16,
  parameter logic [3:0]  UNLOCK_KEY = 4'h2,
  parameter logic [7:0]  ERASE_CODE = 8'h55
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [4:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  output logic         arr_prog,
  output logic         arr_erase,
  output logic [31:0]  arr_addr,
  output logic [127:0] arr_wdata,
  output logic [3:0]   arr_wmask,
  output logic         irq
);

  localparam int unsigned SPAN = PAGE_LSB + PAGE_SEL_W;
  localparam int unsigned MAXL = (PROG_LAT > ERASE_LAT) ? PROG_LAT : ERASE_LAT;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  logic [31:0]   tgt_addr;
  logic [31:0]   wd [4];
  logic [3:0]    unlock;
  logic [7:0]    ekey;
  logic          wide, prog_go, erase_go, busy;
  logic [CW-1:0] cnt;
  logic          done_f, fail_f, done_en, fail_en;

  wire [2:0] idx  = bus_addr[4:2];
  wire       wr   = bus_sel & bus_wr;

  wire       n_prog   = bus_wdata[0];
  wire       n_erase  = bus_wdata[1];
  wire       n_wide   = bus_wdata[4];
  wire [3:0] n_unlock = bus_wdata[11:8];
  wire [7:0] n_key    = bus_wdata[23:16];

  wire ctrl_wr  = wr && idx == 3'd5 && !busy;
  wire intr_wr  = wr && idx == 3'd6;
  wire in_range = (tgt_addr >> SPAN) == 32'd0;
  wire aligned  = n_wide ? (tgt_addr[3:0] == 4'd0) : (tgt_addr[1:0] == 2'd0);
  wire cmd_req  = ctrl_wr && (n_prog || n_erase);
  wire cmd_ok   = n_unlock == UNLOCK_KEY && in_range && (n_prog ^ n_erase) &&
                  (n_prog ? aligned : n_key == ERASE_CODE);
  wire start_p  = cmd_req && cmd_ok && n_prog;
  wire start_e  = cmd_req && cmd_ok && n_erase;
  wire cmd_fail = cmd_req && !cmd_ok;
  wire finish   = busy && cnt == '0;

  wire [127:0] narrow_data = {96'd0, wd[0]} << (32 * tgt_addr[3:2]);
  wire [3:0]   narrow_mask = 4'b0001 << tgt_addr[3:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_addr <= '0;
      for (int i = 0; i < 4; i++) wd[i] <= '0;
    end else if (wr) begin
      if (idx == 3'd0) tgt_addr <= bus_wdata;
      for (int i = 0; i < 4; i++)
        if (idx == 3'(i + 1)) wd[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock   <= '0;
      ekey     <= '0;
      wide     <= 1'b0;
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
    end else if (ctrl_wr) begin
      unlock   <= cmd_fail ? 4'd0 : n_unlock;
      ekey     <= n_key;
      wide     <= n_wide;
      prog_go  <= start_p;
      erase_go <= start_e;
      busy     <= start_p | start_e;
      cnt      <= start_p ? CW'(PROG_LAT - 1) : CW'(ERASE_LAT - 1);
    end else if (finish) begin
      busy     <= 1'b0;
      prog_go  <= 1'b0;
      erase_go <= 1'b0;
      unlock   <= '0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_prog  <= 1'b0;
      arr_erase <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      arr_wmask <= '0;
    end else begin
      arr_prog  <= start_p;
      arr_erase <= start_e;
      if (start_p) begin
        arr_addr  <= tgt_addr;
        arr_wdata <= n_wide ? {wd[3], wd[2], wd[1], wd[0]} : narrow_data;
        arr_wmask <= n_wide ? 4'hF : narrow_mask;
      end else if (start_e) begin
        arr_addr  <= (tgt_addr >> PAGE_LSB) << PAGE_LSB;
        arr_wmask <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f  <= 1'b0;
      fail_f  <= 1'b0;
      done_en <= 1'b0;
      fail_en <= 1'b0;
    end else begin
      done_f <= (done_f & ~(intr_wr & bus_wdata[0])) | finish;
      fail_f <= (fail_f & ~(intr_wr & bus_wdata[1])) | cmd_fail;
      if (intr_wr) begin
        done_en <= bus_wdata[8];
        fail_en <= bus_wdata[9];
      end
    end
  end

  assign irq = (done_f & done_en) | (fail_f & fail_en);

  always_comb begin
    case (idx)
      3'd0:    bus_rdata = tgt_addr;
      3'd1:    bus_rdata = wd[0];
      3'd2:    bus_rdata = wd[1];
      3'd3:    bus_rdata = wd[2];
      3'd4:    bus_rdata = wd[3];
      3'd5:    bus_rdata = {busy, 7'd0, ekey, 4'd0, unlock, 3'd0, wide, 2'd0, erase_go, prog_go};
      3'd6:    bus_rdata = {22'd0, fail_en, done_en, 6'd0, fail_f, done_f};
      default: bus_rdata = '0;
    endcase
  end

  p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_prog && arr_erase));
  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase) |-> busy);
  p_erase_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_erase |-> arr_addr[PAGE_LSB-1:0] == '0);
  p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase) |-> (arr_addr >> SPAN) == 32'd0);
  p_wide_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog && arr_wmask == 4'hF) |-> arr_addr[3:0] == 4'd0);
  p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (unlock == 4'd0 && done_f && !prog_go && !erase_go));
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_en && !fail_en) |-> !irq);

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         arr_prog, arr_erase, irq;
  logic [31:0]  arr_addr;
  logic [127:0] arr_wdata;
  logic [3:0]   arr_wmask;

  int checks = 0, fails = 0;
  int prog_n = 0, erase_n = 0;
  logic [31:0]  cap_addr;
  logic [127:0] cap_data;
  logic [3:0]   cap_mask;

  always #4 clk = ~clk;

  flash_cmd_ctrl i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .arr_prog(arr_prog), .arr_erase(arr_erase), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_wmask(arr_wmask), .irq(irq));

  always @(negedge clk) begin
    if (arr_prog) begin prog_n++; cap_addr = arr_addr; cap_data = arr_wdata; cap_mask = arr_wmask; end
    if (arr_erase) begin erase_n++; cap_addr = arr_addr; end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'(idx * 4); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] d);
    bus_wr = 1'b0; bus_addr = 5'(idx * 4); #1; d = bus_rdata;
  endtask

  task automatic busy_len(output int n);
    logic [31:0] c;
    n = 0;
    rd_reg(5, c);
    while (c[31] && n < 100) begin
      n++;
      @(negedge clk);
      rd_reg(5, c);
    end
  endtask

  task automatic clear_flags(input logic [31:0] en);
    wr_reg(6, en | 32'h3);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int i = 0; i < 7; i++) begin
      rd_reg(i, v);
      chk("R1 register", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 strobes", {arr_prog, arr_erase}, 0);
  endtask

  task automatic t_prog32;
    logic [31:0] v; int n; int p0;
    p0 = prog_n;
    wr_reg(0, 32'h0000_1008);
    wr_reg(1, 32'hA5A5_0001);
    wr_reg(5, 32'h0000_0201);
    busy_len(n);
    chk("R5 busy cycles", n, 4);
    chk("R3 one strobe", prog_n - p0, 1);
    chk("R3 mask", cap_mask, 4'b0100);
    chk("R3 data lane", cap_data, {32'h0, 32'hA5A5_0001, 64'h0});
    chk("R3 addr", cap_addr, 32'h0000_1008);
    rd_reg(5, v);
    chk("R5 R9 ctrl after", v, 0);
    rd_reg(6, v);
    chk("R9 done flag", v, 32'h1);
    chk("R11 irq disabled", irq, 0);
    clear_flags(0);
  endtask

  task automatic t_prog128;
    logic [31:0] v; int n;
    wr_reg(6, 32'h100);
    wr_reg(0, 32'h0002_0010);
    wr_reg(1, 32'h1111_0000);
    wr_reg(2, 32'h2222_0001);
    wr_reg(3, 32'h3333_0002);
    wr_reg(4, 32'h4444_0003);
    wr_reg(5, 32'h0000_0211);
    busy_len(n);
    chk("R5 busy cycles wide", n, 4);
    chk("R4 mask", cap_mask, 4'hF);
    chk("R4 data", cap_data, {32'h4444_0003, 32'h3333_0002, 32'h2222_0001, 32'h1111_0000});
    rd_reg(5, v);
    chk("R9 ctrl after wide", v, 32'h10);
    chk("R11 irq done enabled", irq, 1);
    wr_reg(6, 32'h100);
    rd_reg(6, v);
    chk("R10 write 0 keeps flag", v, 32'h101);
    wr_reg(6, 32'h101);
    rd_reg(6, v);
    chk("R10 write 1 clears", v, 32'h100);
    chk("R11 irq after clear", irq, 0);
    wr_reg(6, 32'h0);
  endtask

  task automatic t_erase;
    logic [31:0] v; int n; int e0;
    e0 = erase_n;
    wr_reg(0, 32'h0003_5ABC);
    wr_reg(5, 32'h0055_0202);
    busy_len(n);
    chk("R7 busy cycles", n, 16);
    chk("R7 one strobe", erase_n - e0, 1);
    chk("R7 page addr", cap_addr, 32'h0003_4000);
    rd_reg(5, v);
    chk("R7 R9 ctrl after", v, 32'h0055_0000);
    rd_reg(6, v);
    chk("R9 erase done", v, 32'h1);
    clear_flags(0);
  endtask

  task automatic expect_fail(input string req, input logic [31:0] addr, input logic [31:0] ctl);
    logic [31:0] v; int p0, e0;
    p0 = prog_n; e0 = erase_n;
    clear_flags(32'h200);
    wr_reg(0, addr);
    wr_reg(5, ctl);
    repeat (20) @(negedge clk);
    chk({req, " no strobe"}, (prog_n - p0) + (erase_n - e0), 0);
    rd_reg(6, v);
    chk({req, " fail flag"}, v, 32'h202);
    chk({req, " R11 irq on fail"}, irq, 1);
    rd_reg(5, v);
    chk({req, " R9 relocked"}, v[11:8], 0);
    chk({req, " not busy"}, v[31], 0);
    clear_flags(0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v; int p0, e0;
    p0 = prog_n; e0 = erase_n;
    wr_reg(0, 32'h0000_4000);
    wr_reg(5, 32'h0055_0202);
    repeat (3) @(negedge clk);
    wr_reg(5, 32'h0000_0201);
    repeat (30) @(negedge clk);
    chk("R12 no prog strobe", prog_n - p0, 0);
    chk("R12 single erase", erase_n - e0, 1);
    rd_reg(5, v);
    chk("R12 ctrl kept", v, 32'h0055_0000);
    rd_reg(6, v);
    chk("R12 only done", v, 32'h1);
    clear_flags(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_prog32;
    t_prog128;
    t_erase;
    expect_fail("R2 locked prog",   32'h0000_1000, 32'h0000_0301);
    expect_fail("R2 locked erase",  32'h0000_2000, 32'h0055_0002);
    expect_fail("R6 bad code",      32'h0000_2000, 32'h0054_0202);
    expect_fail("R8 prog range",    32'h0004_0000, 32'h0000_0201);
    expect_fail("R8 erase range",   32'h8000_0000, 32'h0055_0202);
    expect_fail("R4 wide misalign", 32'h0000_1004, 32'h0000_0211);
    expect_fail("R3 narrow misalign", 32'h0000_1002, 32'h0000_0201);
    expect_fail("R13 both bits",    32'h0000_1000, 32'h0055_0203);
    t_busy_ignore;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule